// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block supports load-locked / store-conditional pairs for several hardware thread contexts that share one memory request port. Each context owns a reservation: a valid flag and the physical address captured by its most recent locked load. A store-conditional from a context is judged against that context's reservation. It gets a result code, and a write-enable tells the memory side whether the store goes ahead.

Any store that actually reaches memory drops every reservation that covers the same 16-byte line, in all contexts including the issuer. These stores are ordinary stores, successful store-conditionals and uncacheable store-conditionals. Each context also keeps a saturating count of consecutive store-conditional failures. A one-cycle warning pulse, tagged with the context number, flags a likely livelock each time that count reaches a nonzero multiple of a configurable period.

The monitor accepts one request per cycle. Responses are registered and appear the cycle after the request. Reservation updates take effect in time for the request that follows.

Top module: `resv_monitor`

## Requirements
- R1: After reset every reservation flag and every failure counter is zero, and the response, write-enable and warning outputs are low.
- R2: A load with the locked attribute captures its address into the issuing context's reservation and sets its flag. A later locked load from the same context replaces the captured address.
- R3: A store-conditional with the uncacheable attribute returns code 2, drives the memory write-enable, and resets that context's failure counter to zero, whatever the state of the reservation.
- R4: A cacheable store-conditional from a context whose flag is clear returns code 0. It does not assert the write-enable, and it adds one to that context's failure counter.
- R5: A cacheable store-conditional whose address differs from the captured address in bits above bit 3 fails as in R4 and clears the issuing context's flag. Addresses that differ only in bits 3..0 match.
- R6: A cacheable store-conditional with a set flag and a matching address returns code 1, asserts the write-enable and resets the context's failure counter to zero.
- R7: Every request that asserts the write-enable (plain store, code 1 or code 2) clears the flag of each context whose captured address matches the store address above bit 3. Contexts with other lines keep their reservations.
- R8: When a failure raises a counter to a nonzero multiple of WARN_PERIOD, the warning output pulses for exactly one cycle, alongside that response, with warn_ctx equal to the failing context.
- R9: A failure counter at its maximum value stays there on further failures and raises no new warning.
- R10: Responses appear one cycle after the request: resp_valid only for store-conditionals, mem_we only for stores, and both low after an idle cycle.
- R11: A load without the locked attribute leaves every reservation untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked attribute (locked load / store-conditional) |
| req_uncached | input | 1 | Uncacheable attribute |
| resp_valid | output | 1 | A store-conditional result is present |
| resp_code | output | 2 | 0 fail, 1 success, 2 uncacheable |
| mem_we | output | 1 | The previous request writes memory |
| fail_cnt | output | NCTX*CNT_W | Consecutive-failure counters, context k at bits k*CNT_W upward |
| warn_pulse | output | 1 | Livelock warning, one cycle |
| warn_ctx | output | CTX_W | Context the warning refers to |

## Verification
The assertions assume that req_ctx always names an existing context and that at most one request arrives per cycle. They also assume that a locked load never coincides with a store, which the single request bus guarantees. The bench drives only context numbers below NCTX and changes inputs on the falling edge. It lowers req_valid between bursts so the idle-cycle properties are exercised too. It shrinks the counter width and the warning period so that warning multiples and saturation are reached within a short run.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_OK       = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;

  // Two addresses fall in the same reservation line when they agree above LSB.
  function automatic logic same_line(logic [63:0] a, logic [63:0] b, int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

endpackage

// File: rtl/resv_decode.sv
module resv_decode
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 4
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  input  logic              req_locked,
  input  logic              req_uncached,
  input  logic              own_flag,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              is_sc,
  output logic              ll_set,
  output logic              sc_ok,
  output logic              sc_fail,
  output logic              sc_uc,
  output logic              do_write,
  output sc_code_e          code
);

  logic line_hit;

  always_comb begin
    line_hit = same_line(64'(req_addr), 64'(own_addr), LINE_LSB);
    is_sc    = req_valid && req_store && req_locked;
    ll_set   = req_valid && !req_store && req_locked;
    sc_uc    = is_sc && req_uncached;
    sc_ok    = is_sc && !req_uncached && own_flag && line_hit;
    sc_fail  = is_sc && !req_uncached && !sc_ok;
    do_write = req_valid && req_store && !sc_fail;
    if (sc_uc)      code = SC_UNCACHED;
    else if (sc_ok) code = SC_OK;
    else            code = SC_FAIL;
  end

endmodule

// File: rtl/resv_ctx.sv
module resv_ctx
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int LINE_LSB    = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_set,
  input  logic              sc_fail,
  input  logic              cnt_clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              flag_q,
  output logic [ADDR_W-1:0] lock_addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              warn_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic on_period(logic [CNT_W-1:0] v);
    return (v != '0) && ((64'(v) % 64'(WARN_PERIOD)) == 64'd0);
  endfunction

  logic             snoop_hit;
  logic             drop;
  logic             cnt_bump;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    snoop_hit = wr_en && flag_q && same_line(64'(addr_in), 64'(lock_addr_q), LINE_LSB);
    drop      = snoop_hit || sc_fail;
    cnt_bump  = sc_fail && (cnt_q != CNT_MAX);
    cnt_next  = cnt_q + CNT_W'(1);
    warn_hit  = cnt_bump && on_period(cnt_next);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q      <= 1'b0;
      lock_addr_q <= '0;
      cnt_q       <= '0;
    end else begin
      if (ll_set) begin
        flag_q      <= 1'b1;
        lock_addr_q <= addr_in;
      end else if (drop) begin
        flag_q <= 1'b0;
      end
      if (cnt_clear)     cnt_q <= '0;
      else if (cnt_bump) cnt_q <= cnt_next;
    end
  end

  AST_LL_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    ll_set |=> flag_q && lock_addr_q == $past(addr_in));  // R2
  AST_FAIL_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |=> !flag_q);  // R5
  AST_SNOOP_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !ll_set) |=> !flag_q);  // R7
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fail && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);  // R9
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> cnt_q == '0);  // R3

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NCTX        = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000,
  parameter int LINE_LSB    = 4,
  localparam int CTX_W      = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [CTX_W-1:0]       req_ctx,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_store,
  input  logic                   req_locked,
  input  logic                   req_uncached,
  output logic                   resp_valid,
  output logic [1:0]             resp_code,
  output logic                   mem_we,
  output logic [NCTX*CNT_W-1:0]  fail_cnt,
  output logic                   warn_pulse,
  output logic [CTX_W-1:0]       warn_ctx
);

  logic [NCTX-1:0]   flag_v;
  logic [ADDR_W-1:0] laddr_v [NCTX];
  logic [NCTX-1:0]   warn_v;

  logic              own_flag;
  logic [ADDR_W-1:0] own_addr;
  logic              is_sc, ll_set, sc_ok, sc_fail, sc_uc, do_write;
  sc_code_e          code;

  always_comb begin
    own_flag = 1'b0;
    own_addr = '0;
    for (int k = 0; k < NCTX; k++) begin
      if (CTX_W'(k) == req_ctx) begin
        own_flag = flag_v[k];
        own_addr = laddr_v[k];
      end
    end
  end

  resv_decode #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_decode (
    .req_valid, .req_addr, .req_store, .req_locked, .req_uncached,
    .own_flag, .own_addr,
    .is_sc, .ll_set, .sc_ok, .sc_fail, .sc_uc, .do_write, .code
  );

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    logic sel;
    assign sel = (req_ctx == CTX_W'(g));
    resv_ctx #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_LSB(LINE_LSB), .WARN_PERIOD(WARN_PERIOD)
    ) u_ctx (
      .clk, .rst_n,
      .ll_set     (ll_set && sel),
      .sc_fail    (sc_fail && sel),
      .cnt_clear  ((sc_ok || sc_uc) && sel),
      .wr_en      (do_write),
      .addr_in    (req_addr),
      .flag_q     (flag_v[g]),
      .lock_addr_q(laddr_v[g]),
      .cnt_q      (fail_cnt[g*CNT_W +: CNT_W]),
      .warn_hit   (warn_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= SC_FAIL;
      mem_we     <= 1'b0;
      warn_pulse <= 1'b0;
      warn_ctx   <= '0;
    end else begin
      resp_valid <= is_sc;
      resp_code  <= code;
      mem_we     <= do_write;
      warn_pulse <= |warn_v;
      warn_ctx   <= req_ctx;
    end
  end

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == SC_FAIL) |-> !mem_we);  // R4
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_code != 2'd3);  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !mem_we && !warn_pulse);  // R10
  AST_WARN_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> resp_valid && resp_code == SC_FAIL);  // R8
  AST_WARN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(warn_v));  // R8
  AST_SC_WRITE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code != SC_FAIL) |-> mem_we);  // R6

endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;

  localparam int NCTX = 4;
  localparam int AW   = 32;
  localparam int CW   = 4;
  localparam int WP   = 5;
  localparam int CTXW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CTXW-1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_store = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
  logic resp_valid, mem_we, warn_pulse;
  logic [1:0] resp_code;
  logic [NCTX*CW-1:0] fail_cnt;
  logic [CTXW-1:0] warn_ctx;

  always #10 clk = ~clk;  // 50 MHz

  resv_monitor #(.NCTX(NCTX), .ADDR_W(AW), .CNT_W(CW), .WARN_PERIOD(WP)) i_resv_monitor (
    .clk, .rst_n, .req_valid, .req_ctx, .req_addr, .req_store, .req_locked, .req_uncached,
    .resp_valid, .resp_code, .mem_we, .fail_cnt, .warn_pulse, .warn_ctx
  );

  // behavioural reference state
  bit          m_flag [NCTX];
  int unsigned m_addr [NCTX];
  int          m_cnt  [NCTX];
  int checks = 0;
  int errors = 0;

  bit e_rv, e_we, e_warn;
  int e_code, e_wctx;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "resp_valid", int'(resp_valid), int'(e_rv));
    if (e_rv) chk(tag, "resp_code", int'(resp_code), e_code);
    chk(tag, "mem_we", int'(mem_we), int'(e_we));
    chk(tag, "warn_pulse", int'(warn_pulse), int'(e_warn));
    if (e_warn) chk(tag, "warn_ctx", int'(warn_ctx), e_wctx);
    for (int k = 0; k < NCTX; k++)
      chk(tag, $sformatf("fail_cnt[%0d]", k), int'(fail_cnt[k*CW +: CW]), m_cnt[k]);
  endtask

  // One request (or idle when v=0); the model predicts; outputs compared next negedge.
  task automatic req(string tag, bit v, int c, int unsigned a, bit st, bit lk, bit uc);
    bit wr;
    e_rv = 0; e_we = 0; e_warn = 0; e_code = 0; e_wctx = c;
    if (v) begin
      if (!st && lk) begin
        m_flag[c] = 1; m_addr[c] = a;
      end else if (st) begin
        wr = 1;
        if (lk) begin
          e_rv = 1;
          if (uc) begin
            e_code = 2; m_cnt[c] = 0;
          end else if (m_flag[c] && (m_addr[c] / 16 == a / 16)) begin
            e_code = 1; m_cnt[c] = 0;
          end else begin
            e_code = 0; wr = 0; m_flag[c] = 0;
            if (m_cnt[c] < CMAX) begin
              m_cnt[c]++;
              if (m_cnt[c] % WP == 0) e_warn = 1;
            end
          end
        end
        e_we = wr;
        if (wr)
          for (int k = 0; k < NCTX; k++)
            if (m_flag[k] && m_addr[k] / 16 == a / 16) m_flag[k] = 0;
      end
    end
    req_valid = v; req_ctx = CTXW'(c); req_addr = a;
    req_store = st; req_locked = lk; req_uncached = uc;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ll(string t, int c, int unsigned a); req(t, 1, c, a, 0, 1, 0); endtask
  task automatic sc(string t, int c, int unsigned a); req(t, 1, c, a, 1, 1, 0); endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCTX; k++) begin m_flag[k] = 0; m_addr[k] = 0; m_cnt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    e_rv = 0; e_we = 0; e_warn = 0;
    compare("R1");
    req("R10 idle", 0, 0, 0, 0, 0, 0);
    // R4: no reservation
    sc("R4", 0, 32'h100);
    // R6, R5: match inside line
    ll("R2", 0, 32'h100);
    sc("R6 R5 same line", 0, 32'h10C);
    sc("R7 own cleared", 0, 32'h100);
    // R5 mismatch
    ll("R2", 1, 32'h200);
    sc("R5 other line", 1, 32'h210);
    sc("R5 flag dropped", 1, 32'h200);
    // R2 replacement
    ll("R2", 2, 32'h300);
    ll("R2 replace", 2, 32'h400);
    sc("R2 old addr", 2, 32'h300);
    ll("R2", 2, 32'h400);
    sc("R2 new addr", 2, 32'h404);
    // R7 snoop by plain store from another context
    ll("R2", 0, 32'h500);
    ll("R2", 1, 32'h508);
    ll("R2", 2, 32'h600);
    req("R7 store", 1, 3, 32'h50F, 1, 0, 0);
    sc("R7 ctx0 lost", 0, 32'h500);
    sc("R7 ctx1 lost", 1, 32'h508);
    sc("R7 ctx2 kept", 2, 32'h600);
    // R3 uncached SC clears counter, writes, snoops
    ll("R2", 0, 32'h700);
    req("R3 uncached", 1, 1, 32'h700, 1, 1, 1);
    sc("R3 R7 snooped", 0, 32'h700);
    // R11 plain load leaves reservation
    ll("R2", 0, 32'h800);
    req("R11 load", 1, 0, 32'h900, 0, 0, 0);
    req("R11 load", 1, 0, 32'h800, 0, 0, 1);
    sc("R11 kept", 0, 32'h800);
    // R8, R9: repeated failures on ctx3
    for (int i = 0; i < 19; i++) sc("R8 R9 fail run", 3, 32'hA00);
    req("R10 idle", 0, 0, 0, 0, 0, 0);
    req("R9 uncached reset", 1, 3, 32'hA00, 1, 1, 1);
    for (int i = 0; i < 5; i++) sc("R8 again", 3, 32'hA00);
    req("R10 idle", 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule